// File: doc/BRIEF.md
# Lock-Protected System Control Register File

This block is a bank of board-level control and status registers on a simple 32-bit bus that is addressed by word. Each access is a single cycle. When a read is selected, the read data and the error flag are combinational from the word address. A write takes effect at the next rising clock edge. The bank reports two fixed words: an identification word and a status word. It holds the oscillator and auxiliary-oscillator settings behind a 16-bit key. Those two registers accept writes only while the key value is loaded in the lock register.

The control register keeps two bits:

- a boot-remap bit, which drives the `remapOn` level (1 hides the boot flash at address zero);
- an indicator bit.

Writing a one to bit 3 of the control register requests a system reset. The request is a one-cycle pulse on `resetReq`.

The bank also provides:

- two flag words, each with its own set address and clear address;
- two plain read/write words for memory settings;
- a read-only window of memory presence-detect bytes;
- a 32-bit counter that advances on each pulse of a reference tick input.

Any offset the bank does not implement answers with `busErr`. Such a read returns zero, and such a write changes nothing.

Top module: `sysctl_regfile`

## Requirements
- R1: A read of word offset 0 returns 0x411A3001, offset 1 returns 0, and offset 4 returns 0x00100000. Offsets 32 to 35 read 0 and accept writes without error, and those writes have no effect.
- R2: After reset the registers hold these values:
  - oscillator (offset 2): 0x01000048;
  - auxiliary oscillator (offset 7): 0x0007FEFF;
  - memory setting (offset 8): 0x00011122 ORed with a size code taken from parameter MEM_MB (0x10 if at least 256, 0x0C if at least 128, 0x08 if at least 64, 0x04 if at least 32, else 0);
  - init (offset 9): 0x00000112;
  - lock, control, both flag words and the counter: 0;
  - `remapOn`: 0.
- R3: A write to offset 5 stores only data bits 15:0. A read of offset 5 returns 0x0001A05F when the stored value is 0xA05F, and otherwise returns the stored value zero-extended.
- R4: A write to offset 2 or offset 7 replaces that register only while the stored lock value is 0xA05F. At any other lock value the write is dropped, and no error is raised.
- R5: A write to offset 3 stores data bits 0 and 2 only. A read of offset 3 returns those two bits in place, with every other bit 0 (bit 3 included). `resetReq` is high for exactly the one cycle after a write to offset 3 with data bit 3 set, and is low at all other times.
- R6: `remapOn` equals the stored control bit 2: 1 means the flash is hidden, 0 means the flash is visible at address zero.
- R7: For the flag words:
  - a write to offset 12 ORs the data into the flag word;
  - a write to offset 13 clears the data's set bits in it;
  - a read of offset 12 returns the flag word.
  Offsets 14 and 15 do the same for a second, non-volatile flag word, which is read at offset 14.
- R8: A read of word offset w, for w from 64 to 127, returns a presence-detect byte at bits 7:0 with the upper bits 0. For w from 73 to 83 the byte is the ASCII text "BOARD-SDRAM", one character per offset in order starting at 73. Every other offset in the window returns 0.
- R9: A read of offset 10 returns the count of cycles in which `refTick` was high since reset, modulo 2^32.
- R10: The offsets that can be read are 0–5, 7–10, 12, 14, 32–35 and 64–127. The offsets that can be written are 2, 3, 5, 7–9, 12–15 and 32–35. A selected access to an offset outside its set raises `busErr` in the same cycle. Such a read returns 0, and such a write changes no state.
- R11: Offsets 8 and 9 store and return the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe for the current cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (7) | Word offset |
| busWdata | input | 32 | Write data |
| refTick | input | 1 | Reference tick enable that advances the counter |
| busRdata | output | 32 | Read data, combinational |
| busErr | output | 1 | Access to an unimplemented offset |
| resetReq | output | 1 | One-cycle system reset request |
| remapOn | output | 1 | Boot remap level (1 = flash hidden) |

## Verification
After reset, and again after each group of write patterns, the bench reads all 128 word offsets. It compares every value and every error flag with a model that it builds from the requirements, so a decode fault at any offset shows up as a wrong word or a wrong flag.

The write patterns cover the following:

- **Lock key:** the oscillator registers are written with the exact key loaded, with no key loaded, and with a value one below the key. This separates a true 16-bit compare from a partial one. A key written with non-zero upper bits shows whether the upper half is masked.
- **Control register:** control writes with bit 3 set and clear separate the reset pulse from the stored bits.
- **Flag words:** overlapping set and clear masks separate the OR and AND-NOT behaviour of the two flag words.
- **Illegal writes:** writes to read-only and unmapped offsets, each followed by a full sweep, show that an illegal write leaves every register unchanged.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_STAT, RD_OSC, RD_CTRL, RD_LOCK, RD_AUX,
    RD_SDRAM, RD_INIT, RD_CNT, RD_FLAGS, RD_NVF, RD_SPD
  } rdSel_e;

  typedef struct packed {
    logic wrOsc;
    logic wrAux;
    logic wrCtrl;
    logic wrLock;
    logic wrSdram;
    logic wrInit;
    logic flagSet;
    logic flagClr;
    logic nvSet;
    logic nvClr;
  } wrStb_t;

  localparam logic [31:0] ID_WORD    = 32'h411A3001;
  localparam logic [31:0] STAT_WORD  = 32'h00100000;
  localparam logic [31:0] OSC_RST    = 32'h01000048;
  localparam logic [31:0] AUX_RST    = 32'h0007FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h00011122;
  localparam logic [31:0] INIT_RST   = 32'h00000112;

  localparam int          TAG_FIRST = 73;
  localparam int          TAG_LEN   = 11;
  localparam logic [87:0] SPD_TAG   = "BOARD-SDRAM";

  function automatic logic [31:0] sdramSizeCode(input int memMb);
    if (memMb >= 256)      return 32'h10;
    else if (memMb >= 128) return 32'h0C;
    else if (memMb >= 64)  return 32'h08;
    else if (memMb >= 32)  return 32'h04;
    else                   return 32'h00;
  endfunction

  function automatic logic [7:0] spdByte(input int idx);
    if (idx >= TAG_FIRST && idx < TAG_FIRST + TAG_LEN)
      return SPD_TAG[8*(TAG_FIRST + TAG_LEN - 1 - idx) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              lockOpen,
  output wrStb_t            stb,
  output rdSel_e            rdSel,
  output logic              accErr
);

  logic [31:0] addrW;
  logic        rdOk;
  logic        wrOk;
  rdSel_e      rdPick;

  assign addrW = 32'(busAddr);

  always_comb begin
    rdOk   = 1'b0;
    wrOk   = 1'b0;
    rdPick = RD_ZERO;
    case (addrW) inside
      0:         begin rdOk = 1'b1; rdPick = RD_ID; end
      1:         begin rdOk = 1'b1; end
      2:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_OSC; end
      3:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_CTRL; end
      4:         begin rdOk = 1'b1; rdPick = RD_STAT; end
      5:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_LOCK; end
      7:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_AUX; end
      8:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_SDRAM; end
      9:         begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_INIT; end
      10:        begin rdOk = 1'b1; rdPick = RD_CNT; end
      12:        begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_FLAGS; end
      13, 15:    begin wrOk = 1'b1; end
      14:        begin rdOk = 1'b1; wrOk = 1'b1; rdPick = RD_NVF; end
      [32:35]:   begin rdOk = 1'b1; wrOk = 1'b1; end
      [64:127]:  begin rdOk = 1'b1; rdPick = RD_SPD; end
      default:   begin rdOk = 1'b0; end
    endcase
  end

  always_comb begin
    stb = '0;
    if (busSel && busWrite) begin
      stb.wrOsc   = (addrW == 32'd2) && lockOpen;
      stb.wrCtrl  = (addrW == 32'd3);
      stb.wrLock  = (addrW == 32'd5);
      stb.wrAux   = (addrW == 32'd7) && lockOpen;
      stb.wrSdram = (addrW == 32'd8);
      stb.wrInit  = (addrW == 32'd9);
      stb.flagSet = (addrW == 32'd12);
      stb.flagClr = (addrW == 32'd13);
      stb.nvSet   = (addrW == 32'd14);
      stb.nvClr   = (addrW == 32'd15);
    end
  end

  assign rdSel  = (busSel && !busWrite && rdOk) ? rdPick : RD_ZERO;
  assign accErr = busSel && (busWrite ? !wrOk : !rdOk);

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int          MEM_MB = 128,
  parameter logic [15:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wrStb_t            stb,
  input  rdSel_e            rdSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              refTick,
  output logic [31:0]       rdata,
  output logic              lockOpen,
  output logic              resetReq,
  output logic              remapOn
);

  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdramSizeCode(MEM_MB);

  logic [31:0] oscReg, auxReg, sdramReg, initReg, flagReg, nvReg, refCnt;
  logic [15:0] lockReg;
  logic        ctrlRemap, ctrlLed, rstPulse;

  assign lockOpen = (lockReg == KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oscReg    <= OSC_RST;
      auxReg    <= AUX_RST;
      sdramReg  <= SDRAM_RST;
      initReg   <= INIT_RST;
      lockReg   <= '0;
      ctrlRemap <= 1'b0;
      ctrlLed   <= 1'b0;
      rstPulse  <= 1'b0;
    end else begin
      if (stb.wrOsc)   oscReg   <= busWdata;
      if (stb.wrAux)   auxReg   <= busWdata;
      if (stb.wrSdram) sdramReg <= busWdata;
      if (stb.wrInit)  initReg  <= busWdata;
      if (stb.wrLock)  lockReg  <= busWdata[15:0];
      if (stb.wrCtrl) begin
        ctrlRemap <= busWdata[2];
        ctrlLed   <= busWdata[0];
      end
      rstPulse <= stb.wrCtrl && busWdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagReg <= '0;
      nvReg   <= '0;
    end else begin
      if (stb.flagSet)      flagReg <= flagReg | busWdata;
      else if (stb.flagClr) flagReg <= flagReg & ~busWdata;
      if (stb.nvSet)        nvReg   <= nvReg | busWdata;
      else if (stb.nvClr)   nvReg   <= nvReg & ~busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       refCnt <= '0;
    else if (refTick) refCnt <= refCnt + 32'd1;
  end

  always_comb begin
    case (rdSel)
      RD_ID:    rdata = ID_WORD;
      RD_STAT:  rdata = STAT_WORD;
      RD_OSC:   rdata = oscReg;
      RD_CTRL:  rdata = {29'b0, ctrlRemap, 1'b0, ctrlLed};
      RD_LOCK:  rdata = {15'b0, lockOpen, lockReg};
      RD_AUX:   rdata = auxReg;
      RD_SDRAM: rdata = sdramReg;
      RD_INIT:  rdata = initReg;
      RD_CNT:   rdata = refCnt;
      RD_FLAGS: rdata = flagReg;
      RD_NVF:   rdata = nvReg;
      RD_SPD:   rdata = {24'b0, spdByte(int'(busAddr))};
      default:  rdata = '0;
    endcase
  end

  assign resetReq = rstPulse;
  assign remapOn  = ctrlRemap;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int          MEM_MB = 128,
  parameter logic [15:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              refTick,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              resetReq,
  output logic              remapOn
);

  wrStb_t stb;
  rdSel_e rdSel;
  logic   lockOpen;

  sysctl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .lockOpen (lockOpen),
    .stb      (stb),
    .rdSel    (rdSel),
    .accErr   (busErr)
  );

  sysctl_regs #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .KEY(KEY)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .rdSel    (rdSel),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .refTick  (refTick),
    .rdata    (busRdata),
    .lockOpen (lockOpen),
    .resetReq (resetReq),
    .remapOn  (remapOn)
  );

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busErr,
  input logic              resetReq,
  input logic              remapOn
);

  logic ctrlWr, rstWr;
  assign ctrlWr = busSel && busWrite && (busAddr == ADDR_W'(3));
  assign rstWr  = ctrlWr && busWdata[3];

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstWr |=> resetReq);

  // R5
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rstWr |=> !resetReq);

  // R5
  ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWrite && busAddr == ADDR_W'(3)) |-> (busRdata[31:3] == 29'b0 && !busRdata[1]));

  // R6
  remap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> (remapOn == $past(busWdata[2])));

  // R6
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWr |=> $stable(remapOn));

  // R3
  lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWrite && busAddr == ADDR_W'(5)) |-> (busRdata[31:17] == 15'b0));

  // R10
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && busAddr == ADDR_W'(6)) |-> busErr);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWrite && busErr) |-> (busRdata == 32'b0));

  // R10
  idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busSel |-> !busErr);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .busErr   (busErr),
  .resetReq (resetReq),
  .remapOn  (remapOn)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;

  localparam int ADDR_W = 7;
  localparam int MEM_MB = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic              refTick = 1'b0;
  logic [31:0]       busRdata;
  logic              busErr;
  logic              resetReq;
  logic              remapOn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mOsc, mAux, mCtrl, mLock, mSdram, mInit, mFlags, mNv, mCnt;

  always #2 clk = ~clk;

  sysctl_regfile #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) dut_i (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .refTick(refTick),
    .busRdata(busRdata), .busErr(busErr), .resetReq(resetReq), .remapOn(remapOn)
  );

  function automatic bit isRd(int a);
    return (a <= 5) || (a >= 7 && a <= 10) || a == 12 || a == 14 ||
           (a >= 32 && a <= 35) || (a >= 64 && a <= 127);
  endfunction

  function automatic bit isWr(int a);
    return a == 2 || a == 3 || a == 5 || (a >= 7 && a <= 9) ||
           (a >= 12 && a <= 15) || (a >= 32 && a <= 35);
  endfunction

  function automatic logic [31:0] expData(int a);
    string txt = "BOARD-SDRAM";
    if (!isRd(a)) return 32'h0;
    case (a)
      0:  return 32'h411A3001;
      4:  return 32'h00100000;
      2:  return mOsc;
      3:  return mCtrl;
      5:  return (mLock == 32'hA05F) ? 32'h0001A05F : mLock;
      7:  return mAux;
      8:  return mSdram;
      9:  return mInit;
      10: return mCnt;
      12: return mFlags;
      14: return mNv;
      default: begin
        if (a >= 73 && a <= 83) return {24'b0, txt[a-73]};
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tagOf(int a);
    if (a == 0 || a == 1 || a == 4 || (a >= 32 && a <= 35)) return "R1";
    if (a == 2 || a == 7) return "R4";
    if (a == 3) return "R5";
    if (a == 5) return "R3";
    if (a == 8 || a == 9) return "R11";
    if (a == 10) return "R9";
    if (a >= 12 && a <= 15) return "R7";
    if (a >= 64) return "R8";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a[ADDR_W-1:0];
    #1;
    chk($sformatf("%s read offset %0d", tag, a), busRdata, expData(a));
    chk($sformatf("R10 error flag read offset %0d", a), {31'b0, busErr}, {31'b0, !isRd(a)});
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a[ADDR_W-1:0]; busWdata = d;
    #1;
    chk($sformatf("R10 error flag write offset %0d", a), {31'b0, busErr}, {31'b0, !isWr(a)});
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    if (a == 3) begin
      chk("R5 reset request pulse", {31'b0, resetReq}, {31'b0, d[3]});
      chk("R6 remap level", {31'b0, remapOn}, {31'b0, d[2]});
    end
    case (a)
      2:  if (mLock == 32'hA05F) mOsc = d;
      7:  if (mLock == 32'hA05F) mAux = d;
      3:  mCtrl = d & 32'h5;
      5:  mLock = {16'b0, d[15:0]};
      8:  mSdram = d;
      9:  mInit = d;
      12: mFlags = mFlags | d;
      13: mFlags = mFlags & ~d;
      14: mNv = mNv | d;
      15: mNv = mNv & ~d;
      default: ;
    endcase
    if (a == 3) begin
      @(negedge clk);
      chk("R5 reset request ends after one cycle", {31'b0, resetReq}, 32'b0);
    end
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a++) rd(a, tagOf(a));
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    refTick = 1'b1;
    repeat (n) @(negedge clk);
    refTick = 1'b0;
    mCnt = mCnt + 32'(n);
  endtask

  initial begin
    int sizeCode;
    sizeCode = (MEM_MB >= 256) ? 'h10 : (MEM_MB >= 128) ? 'h0C :
               (MEM_MB >= 64) ? 'h08 : (MEM_MB >= 32) ? 'h04 : 0;
    mOsc = 32'h01000048; mAux = 32'h0007FEFF; mCtrl = 0; mLock = 0;
    mSdram = 32'h00011122 | 32'(sizeCode); mInit = 32'h00000112;
    mFlags = 0; mNv = 0; mCnt = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk("R2 reset remap level", {31'b0, remapOn}, 32'b0);
    chk("R2 reset request idle", {31'b0, resetReq}, 32'b0);
    sweep();

    // R4 locked oscillator writes dropped
    wr(2, 32'hDEAD0001); wr(7, 32'hDEAD0002);
    rd(2, "R4"); rd(7, "R4");
    // R3 key with upper bits set
    wr(5, 32'h1234A05F); rd(5, "R3");
    wr(2, 32'hCAFE0010); wr(7, 32'hCAFE0020);
    rd(2, "R4"); rd(7, "R4");
    wr(5, 32'h0000A05E); rd(5, "R3");
    wr(2, 32'h11111111); rd(2, "R4");
    wr(5, 32'hFFFF0000); rd(5, "R3");
    wr(7, 32'h22222222); rd(7, "R4");

    // R5 / R6 control patterns
    wr(3, 32'hFFFF_FFFF); rd(3, "R5");
    wr(3, 32'h0000_0008); rd(3, "R5");
    wr(3, 32'h0000_0004); rd(3, "R5");
    wr(3, 32'h0000_0001); rd(3, "R5");

    // R7 flag set/clear patterns
    wr(12, 32'h0000F0F0); wr(12, 32'h0F000000); rd(12, "R7");
    wr(13, 32'h000000F0); rd(12, "R7");
    wr(14, 32'hA5A5A5A5); wr(15, 32'hFF00FF00); rd(14, "R7");
    wr(15, 32'hFFFFFFFF); rd(14, "R7"); rd(12, "R7");

    // R11 full-width words
    wr(8, 32'h89ABCDEF); wr(9, 32'h76543210);
    rd(8, "R11"); rd(9, "R11");

    // R1 / R10 ignored and illegal writes
    wr(0, 32'hFFFFFFFF); wr(1, 32'h1); wr(4, 32'h5); wr(6, 32'h7);
    wr(10, 32'h99); wr(11, 32'h1); wr(33, 32'hFFFF); wr(64, 32'h1);
    wr(80, 32'hFF); wr(127, 32'h3);
    sweep();

    // R9 counter
    ticks(5);  rd(10, "R9");
    ticks(37); rd(10, "R9");
    sweep();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule